// File: doc/BRIEF.md
# Memory Bus Handshake Controller

This block sits between a processor-side request port and a word-organized storage array. Each operation starts with the processor presenting a byte address together with a read or write command. The controller captures the address in an address register, waits a programmable number of cycles to model the array access, and then reports completion with a one-cycle memory-function-complete pulse (`mfc`). Read results are placed in a data register that drives the read-data output. Write data is loaded into the same data register when the command is taken.

The address space is byte-addressable. Each word holds four bytes. The upper address bits select the word and the two lowest bits select a byte lane. A byte qualifier on the request narrows a transfer to one lane: a byte write changes only that lane, and a byte read returns that lane zero-extended. The storage is an internal behavioural register file with 2^(ADDR_W-2) words. While an operation is in flight, the controller raises `busy` and ignores new commands. It also leaves one idle cycle after completion, so the cycle time is always longer than the access time.

Top module: `membus_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `mfc` is 0 and `rd_data` is 0.
- R2: While idle, a command with exactly one of `req_rd` or `req_wr` high is taken at the clock edge, and its address is captured. `busy` is high from the following cycle.
- R3: `mfc` is high for exactly one cycle. That cycle starts LATENCY clock edges after the edge that took the command.
- R4: A word read returns, in `rd_data` during the `mfc` cycle, the whole word at index `req_addr[ADDR_W-1:2]`. The value is held until the next command is taken.
- R5: A word write stores all 32 bits of `req_wdata` at the addressed word before `mfc` is raised.
- R6: A byte write (`req_byte`=1) stores only `req_wdata[7:0]`, and only into lane `req_addr[1:0]`. Lane 0 is bits 7:0 and lane 3 is bits 31:24. The other three lanes of the word keep their values.
- R7: A byte read returns the lane selected by `req_addr[1:0]` in `rd_data[7:0]`, with bits 31:8 equal to 0.
- R8: `busy` stays high from the cycle after acceptance through the `mfc` cycle and is low in the cycle after it. Commands presented while `busy` is high are ignored and change neither the memory nor `rd_data`.
- R9: When `req_rd` and `req_wr` are both high, the command is a no-op. `busy` and `mfc` stay low, and the memory is unchanged.
- R10: When a write is taken, the data register loads `req_wdata`. `rd_data` shows that value from the next cycle until the write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | ADDR_W | Byte address of the request |
| req_rd | input | 1 | Read command |
| req_wr | input | 1 | Write command |
| req_byte | input | 1 | 1 selects a single-byte transfer, 0 a full word |
| req_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| busy | output | 1 | Operation in flight; commands are ignored |
| mfc | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Data register contents |

## Verification
The bound checker watches the handshake on every cycle. It checks that `mfc` is a single-cycle pulse, that it arrives exactly LATENCY edges after acceptance, that it occurs only with `busy` high, and that `busy` drops immediately afterwards. It also checks that a legal idle command always raises `busy`, that a conflicting command never does, and that the data register changes only at acceptance or completion. Data correctness can only be shown by the bench's scenarios, which read stored values back through the normal port. Those scenarios cover lane isolation on byte writes, zero-extension on byte reads, and whether commands issued during `busy` or with both strobes high left the memory untouched.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } bus_state_e;
endpackage

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rd,
  input  logic cmd_wr,
  output logic accept,
  output logic complete,
  output logic busy,
  output logic mfc
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  bus_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             legal;

  assign legal    = cmd_rd ^ cmd_wr;
  assign accept   = (st_q == ST_IDLE) && legal;
  assign complete = (st_q == ST_WAIT) && (cnt_q == '0);
  assign busy     = (st_q != ST_IDLE);
  assign mfc      = (st_q == ST_DONE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_WAIT;
          cnt_d = CNT_W'(LATENCY - 1);
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) st_d = ST_DONE;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/membus_regs.sv
module membus_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              complete,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_wr,
  input  logic              in_byte,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic              op_wr,
  output logic              op_byte,
  output logic [DATA_W-1:0] mdr
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [ADDR_W-1:0] mar_d;
  logic              wr_d, byte_d;
  logic [DATA_W-1:0] mdr_d;
  logic [7:0]        sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (mar[OFF_W-1:0] == OFF_W'(b)) sel_byte = arr_rdata[8*b +: 8];
    end
  end

  always_comb begin
    mar_d  = mar;
    wr_d   = op_wr;
    byte_d = op_byte;
    mdr_d  = mdr;
    if (accept) begin
      mar_d  = in_addr;
      wr_d   = in_wr;
      byte_d = in_byte;
      if (in_wr) mdr_d = in_wdata;
    end else if (complete && !op_wr) begin
      mdr_d = op_byte ? {{(DATA_W-8){1'b0}}, sel_byte} : arr_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar     <= '0;
      op_wr   <= 1'b0;
      op_byte <= 1'b0;
      mdr     <= '0;
    end else begin
      mar     <= mar_d;
      op_wr   <= wr_d;
      op_byte <= byte_d;
      mdr     <= mdr_d;
    end
  end
endmodule

// File: rtl/membus_array.sv
module membus_array #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W/8-1:0] lane_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int WORDS = 1 << IDX_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];

    always_ff @(posedge clk) begin
      if (we && lane_en[g]) lane_mem[idx] <= wdata[8*g +: 8];
    end

    assign rdata[8*g +: 8] = lane_mem[idx];
  end
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_byte,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              mfc,
  output logic [DATA_W-1:0] rd_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int IDX_W = ADDR_W - OFF_W;

  logic              accept, complete;
  logic [ADDR_W-1:0] mar;
  logic              op_wr, op_byte;
  logic [DATA_W-1:0] mdr, arr_rdata, arr_wdata;
  logic [BYTES-1:0]  lane_en;

  membus_seq #(.LATENCY(LATENCY)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_rd   (req_rd),
    .cmd_wr   (req_wr),
    .accept   (accept),
    .complete (complete),
    .busy     (busy),
    .mfc      (mfc)
  );

  membus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .complete  (complete),
    .in_addr   (req_addr),
    .in_wr     (req_wr),
    .in_byte   (req_byte),
    .in_wdata  (req_wdata),
    .arr_rdata (arr_rdata),
    .mar       (mar),
    .op_wr     (op_wr),
    .op_byte   (op_byte),
    .mdr       (mdr)
  );

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      lane_en[b] = !op_byte || (mar[OFF_W-1:0] == OFF_W'(b));
    end
  end

  assign arr_wdata = op_byte ? {BYTES{mdr[7:0]}} : mdr;

  membus_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .we      (complete && op_wr),
    .idx     (mar[ADDR_W-1:OFF_W]),
    .lane_en (lane_en),
    .wdata   (arr_wdata),
    .rdata   (arr_rdata)
  );

  assign rd_data = mdr;
endmodule

// File: rtl/membus_ctrl_chk.sv
module membus_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int LATENCY = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_rd,
  input logic              req_wr,
  input logic              busy,
  input logic              mfc,
  input logic [DATA_W-1:0] rd_data
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat_cnt <= '0;
    else if (!busy && (req_rd ^ req_wr)) lat_cnt <= '0;
    else if (busy)                       lat_cnt <= lat_cnt + 16'd1;
  end

  // R3
  mfc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mfc |=> !mfc);

  // R3
  mfc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mfc |-> (lat_cnt == 16'(LATENCY)));

  // R8
  mfc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mfc |-> busy);

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mfc |=> !busy);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (req_rd ^ req_wr)) |=> (busy && !mfc));

  // R9
  conflict_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_rd && req_wr) |=> !busy);

  // R10
  data_reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> (mfc || $rose(busy)));
endmodule

bind membus_ctrl membus_ctrl_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_rd  (req_rd),
  .req_wr  (req_wr),
  .busy    (busy),
  .mfc     (mfc),
  .rd_data (rd_data)
);

// File: tb/membus_ctrl_tb.sv
module membus_ctrl_tb;
  localparam int AW  = 8;
  localparam int LAT = 3;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] req_addr;
  logic          req_rd, req_wr, req_byte;
  logic [31:0]   req_wdata;
  logic          busy, mfc;
  logic [31:0]   rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] got;

  membus_ctrl #(.ADDR_W(AW), .DATA_W(32), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_rd(req_rd),
    .req_wr(req_wr), .req_byte(req_byte), .req_wdata(req_wdata),
    .busy(busy), .mfc(mfc), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_rd = 0; req_wr = 0; req_byte = 0; req_addr = '0; req_wdata = '0;
  endtask

  // Generic operation with full handshake timing checks (R2, R3, R8, R10)
  task automatic do_op(input logic rd, input logic wr, input logic bt,
                       input logic [AW-1:0] a, input logic [31:0] wd,
                       output logic [31:0] res);
    @(negedge clk);
    req_rd = rd; req_wr = wr; req_byte = bt; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(busy === 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
    if (wr) chk(rd_data === wd, "R10 data register loaded", rd_data, wd);
    for (int i = 0; i < LAT; i++) begin
      chk(mfc === 1'b0, "R3 no early mfc", {31'd0, mfc}, 32'd0);
      @(negedge clk);
    end
    chk(mfc === 1'b1, "R3 mfc at latency", {31'd0, mfc}, 32'd1);
    chk(busy === 1'b1, "R8 busy during mfc", {31'd0, busy}, 32'd1);
    res = rd_data;
    @(negedge clk);
    chk(mfc === 1'b0, "R3 mfc single cycle", {31'd0, mfc}, 32'd0);
    chk(busy === 1'b0, "R8 busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy reset", {31'd0, busy}, 32'd0);
    chk(mfc === 1'b0, "R1 mfc reset", {31'd0, mfc}, 32'd0);
    chk(rd_data === 32'd0, "R1 data reset", rd_data, 32'd0);
  endtask

  task automatic t_word();
    logic [31:0] r;
    do_op(0, 1, 0, 8'h00, 32'hDEADBEEF, r);
    do_op(0, 1, 0, 8'hFC, 32'h0BADF00D, r);
    do_op(0, 1, 0, 8'h40, 32'h00000000, r);
    do_op(1, 0, 0, 8'h00, 32'h0, r);
    chk(r === 32'hDEADBEEF, "R4 R5 word read addr 00", r, 32'hDEADBEEF);
    do_op(1, 0, 0, 8'hFC, 32'h0, r);
    chk(r === 32'h0BADF00D, "R4 R5 word read top", r, 32'h0BADF00D);
    do_op(1, 0, 0, 8'h42, 32'h0, r);
    chk(r === 32'h0, "R4 word read ignores low bits", r, 32'h0);
    repeat (3) @(negedge clk);
    chk(rd_data === 32'h0, "R4 read data held", rd_data, 32'h0);
  endtask

  task automatic t_byte();
    logic [31:0] r;
    do_op(0, 1, 0, 8'h30, 32'hA1B2C3D4, r);
    do_op(0, 1, 1, 8'h32, 32'hFFFFFF5E, r);
    do_op(1, 0, 0, 8'h30, 32'h0, r);
    chk(r === 32'hA15EC3D4, "R6 byte write lane 2", r, 32'hA15EC3D4);
    do_op(0, 1, 1, 8'h30, 32'h12345677, r);
    do_op(1, 0, 0, 8'h30, 32'h0, r);
    chk(r === 32'hA15EC377, "R6 byte write lane 0", r, 32'hA15EC377);
    do_op(1, 0, 1, 8'h31, 32'h0, r);
    chk(r === 32'h000000C3, "R7 byte read lane 1", r, 32'h000000C3);
    do_op(1, 0, 1, 8'h33, 32'h0, r);
    chk(r === 32'h000000A1, "R7 byte read lane 3", r, 32'h000000A1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] r;
    do_op(0, 1, 0, 8'h24, 32'h55AA55AA, r);
    @(negedge clk);
    req_wr = 1; req_addr = 8'h20; req_wdata = 32'h11112222;
    @(posedge clk);
    @(negedge clk);
    req_addr = 8'h24; req_wdata = 32'hEEEEEEEE;
    for (int i = 0; i < LAT; i++) @(negedge clk);
    chk(mfc === 1'b1, "R8 first op completes", {31'd0, mfc}, 32'd1);
    chk(rd_data === 32'h11112222, "R8 data reg untouched while busy",
        rd_data, 32'h11112222);
    @(negedge clk);
    idle_inputs();
    chk(busy === 1'b0, "R8 no restart from ignored command", {31'd0, busy}, 32'd0);
    do_op(1, 0, 0, 8'h24, 32'h0, r);
    chk(r === 32'h55AA55AA, "R8 busy write ignored", r, 32'h55AA55AA);
  endtask

  task automatic t_conflict();
    logic [31:0] r;
    @(negedge clk);
    req_rd = 1; req_wr = 1; req_addr = 8'h24; req_wdata = 32'hCAFECAFE;
    @(negedge clk);
    idle_inputs();
    chk(busy === 1'b0, "R9 no busy on conflict", {31'd0, busy}, 32'd0);
    chk(mfc === 1'b0, "R9 no mfc on conflict", {31'd0, mfc}, 32'd0);
    repeat (LAT + 1) @(negedge clk);
    chk(mfc === 1'b0, "R9 no late mfc", {31'd0, mfc}, 32'd0);
    do_op(1, 0, 0, 8'h24, 32'h0, r);
    chk(r === 32'h55AA55AA, "R9 memory unchanged", r, 32'h55AA55AA);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_byte();
    t_busy_ignore();
    t_conflict();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule